// File: doc/BRIEF.md
# DSI Command Queue Packer

This block converts one outgoing display-link command into the 32-bit words of a command-queue memory. A message is opened with a single-cycle start strobe that carries the packet type byte and the payload length. The payload bytes then arrive one per handshake on a byte-wide valid/ready input. Each accepted byte is written straight into the queue memory through a word address and a 4-bit byte-enable mask. Only the byte lane that holds the byte is enabled, so a partially filled word keeps whatever the other lanes already held.

Messages of up to two bytes become short packets. Their payload sits in the upper half of the header word. Longer messages become long packets. Their payload begins in the second word, and the header carries the length. The header word is always written last, after every payload byte. One cycle after the header write, the block raises a done pulse and presents the number of queue words the message occupies. Serialising onto lanes and generating ECC or CRC are left to the downstream engine.

Top module: `cmdq_packer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wr_en_o`, `done_o` and `byte_ready_o` are low.
- R2: A message whose clamped length is greater than 2 is a long packet, and its header bits 7:0 hold 0x02. A message with length 0, 1 or 2 is a short packet, and its header bits 7:0 hold 0x00.
- R3: The header is written to word address 0, with the type byte in bits 15:8. For a long packet, bits 31:16 hold the length and all four byte enables are set. For a short packet, only byte enables 0 and 1 (mask 0x3) are set, and the data bits 31:16 are zero.
- R4: In a long packet, payload byte i is written to word (4+i)/4 in lane (4+i) mod 4. It sits in data bits 8*lane+7:8*lane, with exactly one byte enable set and the other data lanes zero. Lanes that are never enabled keep their earlier memory contents.
- R5: In a short packet, payload byte i is written to word 0 in lane 2+i. The header write that follows leaves those two lanes untouched.
- R6: `byte_ready_o` is high exactly while payload bytes are still owed. Each cycle with both `byte_valid_i` and `byte_ready_o` high produces exactly one payload write, visible on the following cycle.
- R7: The header write appears on the cycle right after the last payload write, or two cycles after start for a zero-length message. `done_o` is high for exactly the one cycle after the header write.
- R8: While `done_o` is high, `size_o` holds 1 + (length+3)/4 for a long packet and 1 for a short packet.
- R9: A start strobe that arrives while a message is in progress has no effect on the writes, the header or the size.
- R10: A length above MAX_LEN (16) is treated as MAX_LEN. The block collects exactly MAX_LEN bytes, and the header length field reads MAX_LEN.
- R11: A cycle in which `byte_ready_o` is high but `byte_valid_i` is low produces no write on the next cycle and consumes no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a message, sampled while idle |
| type_i | input | 8 | Packet type byte |
| len_i | input | LEN_W (5) | Payload length in bytes |
| byte_valid_i | input | 1 | Payload byte present |
| byte_i | input | 8 | Payload byte |
| byte_ready_o | output | 1 | Block can take a payload byte |
| wr_en_o | output | 1 | Queue memory write strobe |
| wr_addr_o | output | ADDR_W (3) | Queue word address |
| wr_data_o | output | 32 | Queue write data |
| wr_be_o | output | 4 | Byte enables of the write |
| done_o | output | 1 | One-cycle message-complete pulse |
| size_o | output | SIZE_W (6) | Queue words used by the message |

## Verification
The bench targets the short/long boundary at lengths 2 and 3. A design that misjudges this boundary puts payload in the wrong word, writes the wrong config code, and reports the wrong size. Zero-length and clamped over-length messages expose off-by-one faults in the byte counter and in the header length field. Gaps in the byte stream and a stray start strobe mid-message catch designs that write on an idle cycle or restart. The bench also keeps a shadow of the queue memory that starts filled with a marker byte. Any design that writes full words instead of single lanes, or lets the short header overwrite its payload, leaves a wrong byte in that shadow.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PAY  = 2'd1,
        PH_HDR  = 2'd2,
        PH_FIN  = 2'd3
    } phase_e;

    localparam logic [7:0] CFG_SHORT = 8'h00;
    localparam logic [7:0] CFG_LONG  = 8'h02;
    localparam int         OFF_SHORT = 2;
    localparam int         OFF_LONG  = 4;
    localparam int         SHORT_MAX = 2;
    localparam int         LANES     = 4;

endpackage

// File: rtl/cmdq_lane_place.sv
module cmdq_lane_place #(
    parameter int POS_W  = 5,
    parameter int ADDR_W = 3
) (
    input  logic [POS_W-1:0]  pos_i,
    input  logic [7:0]        byte_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [3:0]        be_o,
    output logic [31:0]       data_o
);
    // word index is the byte position divided by the lane count
    assign addr_o = ADDR_W'(pos_i >> 2);

    for (genvar l = 0; l < cmdq_pkg::LANES; l++) begin : g_lane
        assign be_o[l]           = (pos_i[1:0] == 2'(l));
        assign data_o[8*l +: 8]  = (pos_i[1:0] == 2'(l)) ? byte_i : 8'h00;
    end
endmodule

// File: rtl/cmdq_header_fmt.sv
module cmdq_header_fmt #(
    parameter int LEN_W  = 5,
    parameter int SIZE_W = 6
) (
    input  logic [7:0]        type_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              is_long_o,
    output logic [31:0]       word_o,
    output logic [3:0]        be_o,
    output logic [SIZE_W-1:0] size_o
);
    import cmdq_pkg::*;

    always_comb begin
        is_long_o = (int'(len_i) > SHORT_MAX);
        if (is_long_o) begin
            word_o = {16'(len_i), type_i, CFG_LONG};
            be_o   = 4'hF;
            size_o = SIZE_W'(1 + ((int'(len_i) + 3) >> 2));
        end else begin
            word_o = {16'h0000, type_i, CFG_SHORT};
            be_o   = 4'h3;
            size_o = SIZE_W'(1);
        end
    end
endmodule

// File: rtl/cmdq_packer.sv
module cmdq_packer #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5,
    parameter int SIZE_W  = 6,
    parameter int ADDR_W  = $clog2(1 + (MAX_LEN + 3) / 4)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [7:0]        type_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    output logic              byte_ready_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [31:0]       wr_data_o,
    output logic [3:0]        wr_be_o,
    output logic              done_o,
    output logic [SIZE_W-1:0] size_o
);
    import cmdq_pkg::*;

    localparam int POS_W     = $clog2(MAX_LEN + OFF_LONG);
    localparam int MAX_WORDS = 1 + (MAX_LEN + 3) / 4;

    typedef struct packed {
        phase_e            phase;
        logic [7:0]        ty;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
        logic              wr_en;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
        logic [3:0]        be;
        logic              done;
        logic [SIZE_W-1:0] size;
    } st_t;

    st_t st_d, st_q;

    logic [LEN_W-1:0]  len_clamp;
    logic              hdr_long;
    logic [31:0]       hdr_word;
    logic [3:0]        hdr_be;
    logic [SIZE_W-1:0] hdr_size;
    logic [POS_W-1:0]  pay_pos;
    logic [ADDR_W-1:0] pay_addr;
    logic [3:0]        pay_be;
    logic [31:0]       pay_data;

    assign len_clamp = (int'(len_i) > MAX_LEN) ? LEN_W'(MAX_LEN) : len_i;

    cmdq_header_fmt #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_hdr (
        .type_i    (st_q.ty),
        .len_i     (st_q.len),
        .is_long_o (hdr_long),
        .word_o    (hdr_word),
        .be_o      (hdr_be),
        .size_o    (hdr_size)
    );

    assign pay_pos = (hdr_long ? POS_W'(OFF_LONG) : POS_W'(OFF_SHORT)) + POS_W'(st_q.idx);

    cmdq_lane_place #(.POS_W(POS_W), .ADDR_W(ADDR_W)) u_place (
        .pos_i  (pay_pos),
        .byte_i (byte_i),
        .addr_o (pay_addr),
        .be_o   (pay_be),
        .data_o (pay_data)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.done  = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ty    = type_i;
                    st_d.len   = len_clamp;
                    st_d.idx   = '0;
                    st_d.phase = (len_clamp != '0) ? PH_PAY : PH_HDR;
                end
            end
            PH_PAY: begin
                if (byte_valid_i) begin
                    st_d.wr_en = 1'b1;
                    st_d.addr  = pay_addr;
                    st_d.be    = pay_be;
                    st_d.data  = pay_data;
                    st_d.idx   = st_q.idx + LEN_W'(1);
                    if (st_q.idx + LEN_W'(1) == st_q.len) st_d.phase = PH_HDR;
                end
            end
            PH_HDR: begin
                st_d.wr_en = 1'b1;
                st_d.addr  = '0;
                st_d.be    = hdr_be;
                st_d.data  = hdr_word;
                st_d.phase = PH_FIN;
            end
            PH_FIN: begin
                st_d.done  = 1'b1;
                st_d.size  = hdr_size;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign byte_ready_o = (st_q.phase == PH_PAY);
    assign wr_en_o      = st_q.wr_en;
    assign wr_addr_o    = st_q.addr;
    assign wr_data_o    = st_q.data;
    assign wr_be_o      = st_q.be;
    assign done_o       = st_q.done;
    assign size_o       = st_q.size;

    // R6: an accepted byte becomes one single-lane write next cycle
    a_r6_accept_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_ready_o && byte_valid_i) |=> (wr_en_o && $countones(wr_be_o) == 1));

    // R11: an idle handshake cycle produces no write
    a_r11_stall_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_ready_o && !byte_valid_i) |=> !wr_en_o);

    // R3 / R7: done follows a header write at word 0 with a legal mask
    a_r7_header_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> ($past(wr_en_o) && $past(wr_addr_o) == '0 &&
                           ($past(wr_be_o) == 4'hF || $past(wr_be_o) == 4'h3)));

    // R7: done lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8: reported size is within the queue
    a_r8_size_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (size_o >= SIZE_W'(1) && int'(size_o) <= MAX_WORDS));

    // R4: every write enables at least one lane
    a_r4_be_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> (wr_be_o != 4'h0));
endmodule

// File: tb/sim_cmdq_packer.sv
`timescale 1ns/1ps
module sim_cmdq_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  ty = 8'h00;
    logic [4:0]  ln = 5'd0;
    logic        bvalid = 1'b0;
    logic [7:0]  bdata = 8'h00;
    logic        byte_ready_o, wr_en_o, done_o;
    logic [2:0]  wr_addr_o;
    logic [31:0] wr_data_o;
    logic [3:0]  wr_be_o;
    logic [5:0]  size_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cmdq_packer u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .type_i(ty), .len_i(ln),
        .byte_valid_i(bvalid), .byte_i(bdata), .byte_ready_o(byte_ready_o),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_be_o(wr_be_o), .done_o(done_o), .size_o(size_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // shadow of the queue memory, byte addressed
    logic [7:0] mem [0:31];

    // behavioural reference model
    int          m_phase = 0;
    int          m_len = 0;
    int          m_idx = 0;
    logic [7:0]  m_ty = 8'h00;
    bit          e_wen = 0;
    bit          e_done = 0;
    int          e_addr = 0;
    logic [3:0]  e_be = 4'h0;
    logic [31:0] e_data = 32'h0;
    int          e_size = 0;
    string       e_tag = "R4";

    always @(negedge clk) begin
        if (!rst_n) begin
            m_phase = 0; e_wen = 0; e_done = 0;
        end else begin
            chk(wr_en_o == e_wen, "R6 write strobe", 32'(wr_en_o), 32'(e_wen));
            if (e_wen && wr_en_o) begin
                chk(int'(wr_addr_o) == e_addr, e_tag, 32'(wr_addr_o), 32'(e_addr));
                chk(wr_be_o == e_be, e_tag, 32'(wr_be_o), 32'(e_be));
                chk(wr_data_o == e_data, e_tag, wr_data_o, e_data);
            end
            chk(done_o == e_done, "R7 done timing", 32'(done_o), 32'(e_done));
            if (e_done && done_o)
                chk(int'(size_o) == e_size, "R8 size", 32'(size_o), 32'(e_size));
            chk(byte_ready_o == (m_phase == 1), "R6 ready", 32'(byte_ready_o), 32'(m_phase == 1));
            if (wr_en_o)
                for (int l = 0; l < 4; l++)
                    if (wr_be_o[l]) mem[int'(wr_addr_o) * 4 + l] = wr_data_o[8*l +: 8];
            e_wen = 0;
            e_done = 0;
            case (m_phase)
                0: if (start) begin
                    m_ty = ty;
                    m_len = (int'(ln) > 16) ? 16 : int'(ln);
                    m_idx = 0;
                    m_phase = (m_len > 0) ? 1 : 2;
                end
                1: if (bvalid) begin
                    int pos;
                    pos = ((m_len > 2) ? 4 : 2) + m_idx;
                    e_wen = 1;
                    e_addr = pos / 4;
                    e_be = 4'(1 << (pos % 4));
                    e_data = 32'(bdata) << (8 * (pos % 4));
                    e_tag = (m_len > 2) ? "R4 long payload" : "R5 short payload";
                    m_idx++;
                    if (m_idx == m_len) m_phase = 2;
                end
                2: begin
                    e_wen = 1;
                    e_addr = 0;
                    e_tag = "R3 header";
                    if (m_len > 2) begin
                        e_be = 4'hF;
                        e_data = {16'(m_len), m_ty, 8'h02};
                    end else begin
                        e_be = 4'h3;
                        e_data = {16'h0000, m_ty, 8'h00};
                    end
                    m_phase = 3;
                end
                default: begin
                    e_done = 1;
                    e_size = (m_len > 2) ? 1 + (m_len + 3) / 4 : 1;
                    m_phase = 0;
                end
            endcase
        end
    end

    function automatic logic [7:0] pay(input logic [7:0] t, input int k);
        return t ^ 8'(k * 37 + 5);
    endfunction

    // gap: 0 = byte every cycle, else idle one cycle in every gap cycles
    task automatic send(input logic [7:0] t, input int len, input int gap, input bit stray, input string tag);
        int n, k, cyc, off;
        logic [7:0] eb [0:19];
        logic [31:0] ew, aw;
        for (int i = 0; i < 32; i++) mem[i] = 8'hAA;
        n = (len > 16) ? 16 : len;
        @(posedge clk); #2;
        start = 1'b1; ty = t; ln = 5'(len);
        @(posedge clk); #2;
        start = 1'b0;
        k = 0; cyc = 0;
        while (k < n) begin
            bvalid = (gap == 0) ? 1'b1 : ((cyc % gap) != 0);
            bdata = pay(t, k);
            if (stray) begin start = 1'b1; ty = ~t; ln = 5'd1; end
            @(negedge clk);
            if (byte_ready_o && bvalid) k++;
            @(posedge clk); #2;
            cyc++;
        end
        bvalid = 1'b0; start = 1'b0;
        for (int w = 0; w < 8 && !done_o; w++) @(negedge clk);
        chk(done_o == 1'b1, {tag, " done reached"}, 32'(done_o), 32'd1);
        for (int i = 0; i < 20; i++) eb[i] = 8'hAA;
        off = (n > 2) ? 4 : 2;
        eb[0] = (n > 2) ? 8'h02 : 8'h00;
        eb[1] = t;
        if (n > 2) begin eb[2] = 8'(n); eb[3] = 8'h00; end
        for (int i = 0; i < n; i++) eb[off + i] = pay(t, i);
        for (int w = 0; w < 5; w++) begin
            ew = {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]};
            aw = {mem[4*w+3], mem[4*w+2], mem[4*w+1], mem[4*w]};
            chk(aw === ew, {tag, " queue word"}, aw, ew);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_en_o && !done_o && !byte_ready_o, "R1 reset state",
            {29'd0, wr_en_o, done_o, byte_ready_o}, 32'd0);
        send(8'h05, 0, 0, 0, "R7 zero length");
        send(8'h15, 1, 0, 0, "R5 short one byte");
        send(8'h23, 2, 0, 0, "R5 short two bytes");
        send(8'h39, 3, 0, 0, "R2 long boundary");
        send(8'h29, 8, 3, 0, "R11 gapped stream");
        send(8'h39, 16, 0, 0, "R4 full length");
        send(8'h4A, 20, 2, 0, "R10 clamped length");
        send(8'h29, 5, 0, 1, "R9 stray start");
        send(8'h0A, 13, 4, 0, "R8 odd length");
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule